// File: doc/BRIEF.md
# Asynchronous serial port with status flags

The block is an 8-bit asynchronous serial transmitter and receiver. It exposes a small register bus through which software controls the port, loads the byte to send and reads the byte received. One status register gathers six flags. Four of them are events: transmit buffer empty, receive buffer full, parity error and transmission finished. The other two carry the multiprocessor bit, one captured from the line and one to be appended to outgoing characters. A one-cycle transfer strobe can load the transmit buffer directly, in place of a software write, so an external mover can feed the port.

Software clears the transmit-empty, receive-full and parity-error flags by a two-step handshake. It first reads the status register while the flag shows 1. The next write to that register, with 0 in the flag's position, then clears it. While the parity-error flag is set, the receiver accepts no new character. The character that failed parity is still stored, but it is not announced as received.

Top module: `uart_flag_unit`

## Requirements
- R1: After reset the status register (address 1) reads 0x90: bit 7 transmit-empty = 1, bit 6 receive-full = 0, bit 5 parity-error = 0, bit 4 transmit-end = 1, bit 3 received MP bit = 0, bit 2 MP bit to send = 0, bits 1:0 = 0. The receive data register (address 3) reads 0 and `txd` is 1.
- R2: A frame is one start bit (0), eight data bits least significant first, one optional extra bit and one stop bit (1). Each bit lasts 16 sample ticks, and a sample tick occurs every DIV clocks. The receiver takes each bit as the majority of samples 7, 8 and 9.
- R3: With parity enabled (control bit 2), the transmitter appends even parity, so that data plus parity hold an even number of ones. A received character whose parity is wrong sets parity-error and is written to the receive data register, while receive-full stays 0.
- R4: While parity-error is 1 no new character is accepted: the receive data register and receive-full keep their values. Reception resumes once the flag is cleared.
- R5: A status write with 0 in bit 7, 6 or 5 clears that flag only if a status read since the previous status write returned the flag as 1. A write with 1 in a flag position, or a write not preceded by such a read, leaves the flag unchanged.
- R6: Clearing receive-enable (control bit 1) leaves parity-error and the received MP bit unchanged.
- R7: Transmit-end is 1 whenever transmit-enable (control bit 0) is 0. It is also set at the end of a stop bit if transmit-empty is 1 at that moment. If transmit-empty is 0 then, the next frame follows with no idle time and transmit-end stays 0.
- R8: Transmit-end is cleared when software clears transmit-empty through the R5 handshake. It is also cleared when the transfer strobe loads `xfer_data` into the transmit data register (address 2), which at the same time sets transmit-empty to 0.
- R9: With multiprocessor mode on (control bit 3), the extra bit of each sent frame is status bit 2, which software can write. The extra bit of each received frame is stored in status bit 3, which writes do not change.
- R10: A good frame places its byte in the receive data register and sets receive-full.
- R11: With transmit-enable 1 and transmit-empty 0, the transmitter moves the byte into its shift register and sets transmit-empty to 1 again on the following clock.
- R12: If parity and multiprocessor mode are both enabled, multiprocessor mode wins: the extra bit is the MP bit and parity is not checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Bus access in this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | 0 control, 1 status, 2 transmit data, 3 receive data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| xfer_req | input | 1 | One-cycle strobe that loads the transmit buffer |
| xfer_data | input | 8 | Byte loaded by `xfer_req` |

## Verification
Bus reads are combinational, so the bench samples `rdata` 2 ns after driving a read, before the edge that arms the flags. Status changes caused by a write or by the strobe appear one clock later. The reload that sets transmit-empty again comes one more clock after that, so the bench reads back on the second falling edge after the write. Receive results arrive about 9.6 bit times after a start edge, and transmit-end rises only about 6 sample ticks later at the end of the stop bit. The bench therefore polls for receive events and reads transmit-end only after a margin of several bit times. Back-to-back checks sample between the two frames' ends.

// File: rtl/uart_flag_unit.sv
module uart_flag_unit #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rxd,
  output logic       txd,
  input  logic       xfer_req,
  input  logic [7:0] xfer_data
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_cnt;
  logic tick;
  assign tick = (div_cnt == DW'(DIV - 1));
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_cnt <= '0;
    else div_cnt <= tick ? '0 : div_cnt + 1'b1;

  logic tx_en, rx_en, par_en, mp_en;
  logic tdre, rdrf, perr, tend, mpb, mpbt;
  logic arm_tdre, arm_rdrf, arm_perr;
  logic [7:0] tdr, rdr;

  logic mp_mode, par_mode, has_x;
  assign mp_mode  = mp_en;
  assign par_mode = par_en & ~mp_en;
  assign has_x    = par_en | mp_en;

  logic rd_stat, wr_stat;
  assign rd_stat = sel & ~wr & (addr == 2'd1);
  assign wr_stat = sel & wr & (addr == 2'd1);

  always_comb
    case (addr)
      2'd0:    rdata = {4'b0, mp_en, par_en, rx_en, tx_en};
      2'd1:    rdata = {tdre, rdrf, perr, tend, mpb, mpbt, 2'b00};
      2'd2:    rdata = tdr;
      default: rdata = rdr;
    endcase

  // receiver
  logic [1:0] rx_meta;
  logic rs, rx_busy, rx_x, maj, rx_done;
  logic [3:0] rx_smp, rx_idx, rx_last;
  logic [1:0] rx_v;
  logic [7:0] rx_sh;
  assign rs      = rx_meta[1];
  assign maj     = (rx_v[0] & rx_v[1]) | (rx_v[0] & rs) | (rx_v[1] & rs);
  assign rx_last = has_x ? 4'd10 : 4'd9;
  assign rx_done = tick & rx_busy & (rx_smp == 4'd9) & (rx_idx == rx_last);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_meta <= 2'b11; rx_busy <= 1'b0; rx_smp <= '0; rx_idx <= '0;
      rx_v <= '0; rx_sh <= '0; rx_x <= 1'b0;
    end else begin
      rx_meta <= {rx_meta[0], rxd};
      if (!rx_en) rx_busy <= 1'b0;
      else if (tick) begin
        if (!rx_busy) begin
          if (!perr && !rs) begin
            rx_busy <= 1'b1; rx_smp <= 4'd1; rx_idx <= '0;
          end
        end else begin
          rx_smp <= rx_smp + 1'b1;
          if (rx_smp == 4'd7) rx_v[0] <= rs;
          if (rx_smp == 4'd8) rx_v[1] <= rs;
          if (rx_smp == 4'd15) rx_idx <= rx_idx + 1'b1;
          if (rx_smp == 4'd9) begin
            if (rx_idx == 4'd0 && maj) rx_busy <= 1'b0;
            else if (rx_idx >= 4'd1 && rx_idx <= 4'd8) rx_sh <= {maj, rx_sh[7:1]};
            else if (rx_idx == 4'd9 && has_x) rx_x <= maj;
            if (rx_idx == rx_last) rx_busy <= 1'b0;
          end
        end
      end
    end

  // transmitter
  logic tx_busy, tx_end, tx_load, tx_xb;
  logic [3:0] tx_smp, tx_idx, tx_last;
  logic [10:0] tx_sh, frame;
  assign tx_xb   = mp_mode ? mpbt : ^tdr;
  assign frame   = has_x ? {1'b1, tx_xb, tdr, 1'b0} : {2'b11, tdr, 1'b0};
  assign tx_last = has_x ? 4'd10 : 4'd9;
  assign tx_end  = tx_busy & tick & (tx_smp == 4'd15) & (tx_idx == tx_last);
  assign tx_load = tx_en & ~tdre & (~tx_busy | tx_end);
  assign txd     = ~tx_busy | tx_sh[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_smp <= '0; tx_idx <= '0; tx_sh <= '1;
    end else if (!tx_en) tx_busy <= 1'b0;
    else if (tx_load) begin
      tx_busy <= 1'b1; tx_sh <= frame; tx_smp <= '0; tx_idx <= '0;
    end else if (tx_end) tx_busy <= 1'b0;
    else if (tx_busy && tick) begin
      tx_smp <= tx_smp + 1'b1;
      if (tx_smp == 4'd15) begin
        tx_sh  <= {1'b1, tx_sh[10:1]};
        tx_idx <= tx_idx + 1'b1;
      end
    end

  // registers and flags
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {tx_en, rx_en, par_en, mp_en} <= '0;
      tdre <= 1'b1; tend <= 1'b1; rdrf <= 1'b0; perr <= 1'b0;
      mpb <= 1'b0; mpbt <= 1'b0;
      {arm_tdre, arm_rdrf, arm_perr} <= '0;
      tdr <= '0; rdr <= '0;
    end else begin
      if (sel && wr && addr == 2'd0) {mp_en, par_en, rx_en, tx_en} <= wdata[3:0];
      if (sel && wr && addr == 2'd2) tdr <= wdata;
      if (rd_stat) begin
        arm_tdre <= arm_tdre | tdre;
        arm_rdrf <= arm_rdrf | rdrf;
        arm_perr <= arm_perr | perr;
      end
      if (wr_stat) begin
        {arm_tdre, arm_rdrf, arm_perr} <= '0;
        mpbt <= wdata[2];
        if (arm_perr && !wdata[5]) perr <= 1'b0;
        if (arm_rdrf && !wdata[6]) rdrf <= 1'b0;
        if (arm_tdre && !wdata[7]) begin tdre <= 1'b0; tend <= 1'b0; end
      end
      if (tx_load) tdre <= 1'b1;
      if (tx_end && tdre) tend <= 1'b1;
      if (xfer_req) begin tdr <= xfer_data; tdre <= 1'b0; tend <= 1'b0; end
      if (rx_done) begin
        rdr <= rx_sh;
        if (par_mode && (^rx_sh ^ rx_x)) perr <= 1'b1;
        else rdrf <= 1'b1;
        if (mp_mode) mpb <= rx_x;
      end
      if (!tx_en) tend <= 1'b1;
    end

  a_r7_tend_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> tend);
  a_r3_per_no_rdrf: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perr) |-> !$rose(rdrf));
  a_r4_hold_rx: assert property (@(posedge clk) disable iff (!rst_n)
    perr |=> !$rose(rx_busy));
  a_r5_per_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(perr) |-> $past(wr_stat && !wdata[5]));
  a_r8_tend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tend) |-> $past(xfer_req || (wr_stat && !wdata[7])));
  a_r11_tx_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(!tdre && tx_en));
endmodule

// File: tb/uart_flag_unit_tb_top.sv
module uart_flag_unit_tb_top;
  localparam int DIV = 2;
  localparam int BIT = 16 * DIV;

  logic clk = 0, rst_n = 0, sel = 0, wr = 0, xfer_req = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, xfer_data = 0, rdata;
  logic txd, b_rxd = 1, use_loop = 0, rxd;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;
  assign rxd = use_loop ? txd : b_rxd;

  uart_flag_unit #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rxd(rxd), .txd(txd), .xfer_req(xfer_req), .xfer_data(xfer_data));

  // data, parity, mp, mpbt, expected received MP bit
  localparam logic [11:0] VEC [0:6] = '{
    {8'hA5, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h3C, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h00, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'hFF, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h81, 1'b0, 1'b1, 1'b1, 1'b1},
    {8'h7E, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h55, 1'b1, 1'b1, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    #2 d = rdata;
    @(negedge clk); sel = 0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic hx, input logic xb);
    logic [10:0] f;
    f = hx ? {1'b1, xb, d, 1'b0} : {2'b11, d, 1'b0};
    for (int i = 0; i < (hx ? 11 : 10); i++) begin
      @(negedge clk); b_rxd = f[i];
      repeat (BIT - 1) @(negedge clk);
    end
  endtask

  task automatic wait_rx(output logic [7:0] s);
    s = 0;
    for (int i = 0; i < 3000; i++) begin
      bus_read(2'd1, s);
      if (s[6] | s[5]) break;
    end
  endtask

  task automatic pulse_xfer(input logic [7:0] d);
    @(negedge clk); xfer_req = 1; xfer_data = d;
    @(negedge clk); xfer_req = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog got expired exp finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    bus_read(2'd1, s); check("R1 status", s, 8'h90);
    bus_read(2'd3, d); check("R1 rxdata", d, 8'h00);
    check("R1 txd", {7'b0, txd}, 8'h01);

    // loopback vector walk: R2 R3 R9 R10 R11 R12
    use_loop = 1;
    foreach (VEC[k]) begin
      bus_write(2'd0, {4'b0, VEC[k][2], VEC[k][3], 2'b11});
      bus_write(2'd2, VEC[k][11:4]);
      bus_read(2'd1, s);
      bus_write(2'd1, {5'b0, VEC[k][1], 2'b0});
      bus_read(2'd1, s);
      check("R11 reload sets empty", {7'b0, s[7]}, 8'h01);
      check("R8 end cleared by software", {7'b0, s[4]}, 8'h00);
      wait_rx(s);
      check("R10 receive-full", {7'b0, s[6]}, 8'h01);
      check("R3 no parity error on loopback", {7'b0, s[5]}, 8'h00);
      bus_read(2'd3, d); check("R2 R10 loopback byte", d, VEC[k][11:4]);
      if (VEC[k][2]) check("R9 R12 received MP bit", {7'b0, s[3]}, {7'b0, VEC[k][0]});
      repeat (10 * BIT) @(negedge clk);
      bus_read(2'd1, s); check("R7 end after last frame", {7'b0, s[4]}, 8'h01);
    end

    // parity error directed, R3
    use_loop = 0;
    bus_write(2'd0, 8'h06);
    bus_read(2'd1, s); bus_write(2'd1, 8'h80);
    send_frame(8'h0F, 1'b1, 1'b1);
    wait_rx(s);
    check("R3 parity error set", {7'b0, s[5]}, 8'h01);
    check("R3 receive-full stays 0", {7'b0, s[6]}, 8'h00);
    bus_read(2'd3, d); check("R3 bad byte stored", d, 8'h0F);
    // R4 hold while error
    send_frame(8'h99, 1'b1, 1'b0);
    repeat (2 * BIT) @(negedge clk);
    bus_read(2'd3, d); check("R4 rxdata held", d, 8'h0F);
    bus_read(2'd1, s); check("R4 receive-full held", {7'b0, s[6]}, 8'h00);
    // R6 receive disable keeps flags
    bus_write(2'd0, 8'h04);
    bus_read(2'd1, s);
    check("R6 parity error kept", {7'b0, s[5]}, 8'h01);
    check("R6 MP bit kept", {7'b0, s[3]}, 8'h01);
    // R5 handshake
    bus_write(2'd1, 8'hA0);
    bus_write(2'd1, 8'h80);
    bus_read(2'd1, s);
    check("R5 no clear without read", {7'b0, s[5]}, 8'h01);
    check("R5 empty kept by writing 1", {7'b0, s[7]}, 8'h01);
    bus_write(2'd1, 8'h80);
    bus_read(2'd1, s);
    check("R5 cleared after read", {7'b0, s[5]}, 8'h00);
    check("R9 MP bit not writable", {7'b0, s[3]}, 8'h01);
    // R4 resume
    bus_write(2'd0, 8'h06);
    send_frame(8'h99, 1'b1, 1'b0);
    wait_rx(s);
    check("R4 resumed receive-full", {7'b0, s[6]}, 8'h01);
    bus_read(2'd3, d); check("R4 resumed byte", d, 8'h99);

    // transfer strobe and chaining, R7 R8
    use_loop = 1;
    bus_write(2'd0, 8'h03);
    bus_read(2'd1, s); bus_write(2'd1, 8'h80);
    pulse_xfer(8'h42);
    bus_read(2'd1, s);
    check("R8 strobe clears end", {7'b0, s[4]}, 8'h00);
    check("R11 strobe byte taken", {7'b0, s[7]}, 8'h01);
    pulse_xfer(8'h43);
    repeat (12 * BIT - 20) @(negedge clk);
    bus_read(2'd1, s); check("R7 chained frame keeps end 0", {7'b0, s[4]}, 8'h00);
    bus_read(2'd3, d); check("R8 first strobe byte", d, 8'h42);
    repeat (12 * BIT) @(negedge clk);
    bus_read(2'd1, s); check("R7 end after chain", {7'b0, s[4]}, 8'h01);
    bus_read(2'd3, d); check("R8 second strobe byte", d, 8'h43);
    // R7 disable mid-frame
    pulse_xfer(8'h11);
    repeat (50) @(negedge clk);
    bus_read(2'd1, s); check("R7 end 0 while sending", {7'b0, s[4]}, 8'h00);
    bus_write(2'd0, 8'h02);
    bus_read(2'd1, s); check("R7 end on disable", {7'b0, s[4]}, 8'h01);
    check("R7 line idle on disable", {7'b0, txd}, 8'h01);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule